// File: doc/BRIEF.md
# Control and status register bank

This block is the software-facing register file of an angle-storage datapath. An AXI4-Lite slave on a slow clock lets software set the command code, a 48-bit start count, fiber delays, parity flags and a read-pacing threshold. Software also fires one-shot actions through trigger bits. Every stored field drives a plain output wire into the datapath. Each trigger bit turns into a single-cycle pulse.

In the other direction, the block keeps snapshots of two status words. Each word is already synchronised into this clock domain and carries its own valid strobe. The block also samples a pulse-per-second level through a short synchroniser. It captures a 48-bit running count so that software can read it as two words without the value tearing between the two reads.

All registers are 32-bit words at byte offset 4*n. Unused bits read as zero. Unmapped offsets complete normally and return zero.

Top module: `csr_bank`

## Requirements
- R1: A write completes when address and data are both presented. The write response is OKAY (bresp = 0) and stays valid until bready is high. No new write is accepted while a response is pending. A byte lane is written only when its strobe bit is set.
- R2: A read returns the word selected by araddr[7:2] with rresp = 0. rvalid and rdata stay stable until rready is high.
- R3: Register n sits at byte offset 4*n. Bits outside each register's defined fields read back as zero, whatever value was written.
- R4: Bit 0 of registers 0, 1, 3, 6 and 7 is a trigger. The matching outputs are go_write_pulse, gc_query_pulse, cfg_load_pulse, angle_save_pulse and gc_out_pulse. A pulse lasts exactly one cycle and follows a write that changes the stored bit from 0 to 1. Writing 1 over a stored 1 gives no pulse. Writing 0 re-arms the trigger.
- R5: Register 2 bits [2:0] drive cmd_code and bit 3 drives cmd_spare. read_angle_mode is high only for code 3, and angle_flush is high only for code 4.
- R6: start_count[31:0] comes from register 4. start_count[47:32] comes from register 5 bits [15:0].
- R7: Register 6 bit 1 drives pm_parity and bit 2 drives am_parity. Register 8 drives rd_pace and register 9 drives spare_thr. Register 10 bits [15:0] drive pm_delay and bits [31:16] drive am_delay. Register 11 bits [15:0] drive out_delay.
- R8: Register 13 bits [8:0] hold the last vstat_in value seen while vstat_vld was high. Input bit k appears at register bit k, so the layout is: [8:7] store-FIFO idle flags, [6:5] its full flags, [4:3] its empty flags, [2] count-output FIFO full, [1] count-input FIFO empty, [0] angle-output FIFO full. The register holds its value while vstat_vld is low.
- R9: Register 14 bits [2:0] hold the last fstat_in value seen while fstat_vld was high. The layout is: [2] count-output FIFO empty, [1] count-input FIFO full, [0] angle-output FIFO empty. The register holds its value otherwise.
- R10: Register 12 bit 0 reports pps_in after a two-stage synchroniser.
- R11: A read of register 15 returns cur_count[31:0] and, in the same cycle, captures cur_count[47:32]. Register 16 bits [15:0] return that captured upper half.
- R12: Reads of offsets above register 16 return zero with an OKAY response. Writes to registers 12 to 16, and to unmapped offsets, change nothing.
- R13: After reset every register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | 8 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 8 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| pps_in | input | 1 | Pulse-per-second level, asynchronous |
| vstat_in | input | 9 | Store-FIFO and queue flag word |
| vstat_vld | input | 1 | Load strobe for vstat_in |
| fstat_in | input | 3 | Second queue flag word |
| fstat_vld | input | 1 | Load strobe for fstat_in |
| cur_count | input | 48 | Running count for readback |
| go_write_pulse | output | 1 | Start-writing trigger pulse |
| gc_query_pulse | output | 1 | Count-query trigger pulse |
| cfg_load_pulse | output | 1 | Register-update trigger pulse |
| angle_save_pulse | output | 1 | Angle-FIFO reset and save trigger pulse |
| gc_out_pulse | output | 1 | Count-output reset and save trigger pulse |
| cmd_code | output | 3 | Command code |
| cmd_spare | output | 1 | Stored spare command bit |
| read_angle_mode | output | 1 | Command code is read-angle |
| angle_flush | output | 1 | Command code is angle-FIFO reset |
| start_count | output | 48 | Count at which angle saving starts |
| pm_parity | output | 1 | Phase-modulator delay parity |
| am_parity | output | 1 | Second-modulator delay parity |
| rd_pace | output | 32 | Read-pacing threshold in cycles |
| spare_thr | output | 32 | Spare threshold word |
| pm_delay | output | 16 | Phase-modulator fiber delay |
| am_delay | output | 16 | Second-modulator fiber delay |
| out_delay | output | 16 | Output-start fiber delay |

## Verification
The assertions check every cycle that a pending write response or read beat holds until it is taken. They check that no write is accepted while a response is pending, and that no trigger output is ever high for two cycles in a row. They also check that each status snapshot loads exactly on its strobe and otherwise holds. The bench scenarios are needed for the rest. Those cover the arm-and-fire sequence of each trigger, byte-strobe merging, reserved-bit masking, the command decode, the synchroniser delay on the PPS bit, the tear-free split read of the count, and the silence of read-only and unmapped offsets.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int REG_W    = 32;
  localparam int NUM_CFG  = 12;   // writable words 0..11
  localparam int NUM_TRIG = 5;

  localparam int REG_PPS  = 12;
  localparam int REG_VST  = 13;
  localparam int REG_FST  = 14;
  localparam int REG_CNTL = 15;
  localparam int REG_CNTH = 16;

  localparam logic [2:0] CMD_READ_ANGLE = 3'd3;
  localparam logic [2:0] CMD_FLUSH      = 3'd4;

  // bits that each writable word keeps
  function automatic logic [REG_W-1:0] cfg_mask(input int idx);
    case (idx)
      0, 1, 3, 7:  cfg_mask = 32'h0000_0001;
      2:           cfg_mask = 32'h0000_000F;
      6:           cfg_mask = 32'h0000_0007;
      5, 11:       cfg_mask = 32'h0000_FFFF;
      4, 8, 9, 10: cfg_mask = 32'hFFFF_FFFF;
      default:     cfg_mask = 32'h0000_0000;
    endcase
  endfunction

  // word that holds trigger t in bit 0
  function automatic int trig_reg(input int t);
    case (t)
      0:       trig_reg = 0;
      1:       trig_reg = 1;
      2:       trig_reg = 3;
      3:       trig_reg = 6;
      default: trig_reg = 7;
    endcase
  endfunction
endpackage

// File: rtl/csr_rst_sync.sv
module csr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb sh_d = {sh_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/csr_axil_port.sv
module csr_axil_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = ADDR_W - 2,
  localparam int STB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STB_W-1:0]  wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic [STB_W-1:0]  wr_strb,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_word
);
  logic              bvalid_q, bvalid_d;
  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              unused_lsb;

  assign unused_lsb = ^{awaddr[1:0], araddr[1:0]};

  // write channel: address and data taken together
  assign awready = awvalid & wvalid & ~bvalid_q;
  assign wready  = awready;
  assign wr_en   = awready;
  assign wr_idx  = awaddr[ADDR_W-1:2];
  assign wr_data = wdata;
  assign wr_strb = wstrb;

  always_comb begin
    bvalid_d = bvalid_q;
    if (wr_en)       bvalid_d = 1'b1;
    else if (bready) bvalid_d = 1'b0;
  end

  // read channel
  assign arready = ~rvalid_q;
  assign rd_en   = arvalid & arready;
  assign rd_idx  = araddr[ADDR_W-1:2];

  always_comb begin
    rvalid_d = rvalid_q;
    rdata_d  = rdata_q;
    if (rd_en) begin
      rvalid_d = 1'b1;
      rdata_d  = rd_word;
    end else if (rready) begin
      rvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      bvalid_q <= bvalid_d;
      rvalid_q <= rvalid_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign bvalid = bvalid_q;
  assign bresp  = 2'b00;
  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign rresp  = 2'b00;
endmodule

// File: rtl/csr_store.sv
module csr_store
  import csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  localparam int STB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STB_W-1:0]  wr_strb,
  output logic [DATA_W-1:0] cfg_word [NUM_CFG],
  output logic [NUM_TRIG-1:0] trig_pulse
);
  logic [DATA_W-1:0] cfg_v [NUM_CFG];

  for (genvar r = 0; r < NUM_CFG; r++) begin : g_word
    localparam logic [DATA_W-1:0] KEEP = DATA_W'(cfg_mask(r));
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] nxt;
    logic              ld;

    assign ld = wr_en && (wr_idx == IDX_W'(r));

    always_comb begin
      nxt = q;
      for (int b = 0; b < STB_W; b++) begin
        if (wr_strb[b]) nxt[8*b +: 8] = wr_data[8*b +: 8];
      end
      nxt = nxt & KEEP;
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) q <= '0;
      else if (ld) q <= nxt;
    end

    assign cfg_v[r] = q;
  end

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    localparam int RI = trig_reg(t);
    logic armed_q;

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) armed_q <= 1'b0;
      else         armed_q <= cfg_v[RI][0];
    end

    assign trig_pulse[t] = cfg_v[RI][0] & ~armed_q;
  end

  assign cfg_word = cfg_v;
endmodule

// File: rtl/csr_status_snap.sv
module csr_status_snap #(
  parameter int VST_W  = 9,
  parameter int FST_W  = 3,
  parameter int HI_W   = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             pps_in,
  input  logic [VST_W-1:0] vstat_in,
  input  logic             vstat_vld,
  input  logic [FST_W-1:0] fstat_in,
  input  logic             fstat_vld,
  input  logic [HI_W-1:0]  cnt_hi_in,
  input  logic             cap_en,
  output logic             pps_s,
  output logic [VST_W-1:0] vsnap_q,
  output logic [FST_W-1:0] fsnap_q,
  output logic [HI_W-1:0]  cap_hi_q
);
  logic [SYNC_N-1:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[SYNC_N-2:0], pps_in};

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign pps_s = sync_q[SYNC_N-1];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        vsnap_q <= '0;
    else if (vstat_vld) vsnap_q <= vstat_in;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        fsnap_q <= '0;
    else if (fstat_vld) fsnap_q <= fstat_in;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cap_hi_q <= '0;
    else if (cap_en) cap_hi_q <= cnt_hi_in;
  end
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int VST_W  = 9,
  parameter int FST_W  = 3,
  parameter int CNT_W  = 48,
  parameter int DLY_W  = 16,
  parameter int SYNC_N = 2,
  localparam int DATA_W = REG_W,
  localparam int STB_W  = DATA_W / 8,
  localparam int IDX_W  = ADDR_W - 2,
  localparam int HI_W   = CNT_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STB_W-1:0]  s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  input  logic              pps_in,
  input  logic [VST_W-1:0]  vstat_in,
  input  logic              vstat_vld,
  input  logic [FST_W-1:0]  fstat_in,
  input  logic              fstat_vld,
  input  logic [CNT_W-1:0]  cur_count,
  output logic              go_write_pulse,
  output logic              gc_query_pulse,
  output logic              cfg_load_pulse,
  output logic              angle_save_pulse,
  output logic              gc_out_pulse,
  output logic [2:0]        cmd_code,
  output logic              cmd_spare,
  output logic              read_angle_mode,
  output logic              angle_flush,
  output logic [CNT_W-1:0]  start_count,
  output logic              pm_parity,
  output logic              am_parity,
  output logic [DATA_W-1:0] rd_pace,
  output logic [DATA_W-1:0] spare_thr,
  output logic [DLY_W-1:0]  pm_delay,
  output logic [DLY_W-1:0]  am_delay,
  output logic [DLY_W-1:0]  out_delay
);
  logic                srst_n;
  logic                wr_en, rd_en;
  logic [IDX_W-1:0]    wr_idx, rd_idx;
  logic [DATA_W-1:0]   wr_data, rd_word;
  logic [STB_W-1:0]    wr_strb;
  logic [DATA_W-1:0]   cfg_word [NUM_CFG];
  logic [NUM_TRIG-1:0] trig_pulse;
  logic                pps_s;
  logic [VST_W-1:0]    vsnap_q;
  logic [FST_W-1:0]    fsnap_q;
  logic [HI_W-1:0]     cap_hi_q;
  logic                cap_en;

  csr_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  csr_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk     (clk),
    .srst_n  (srst_n),
    .awaddr  (s_awaddr),
    .awvalid (s_awvalid),
    .awready (s_awready),
    .wdata   (s_wdata),
    .wstrb   (s_wstrb),
    .wvalid  (s_wvalid),
    .wready  (s_wready),
    .bresp   (s_bresp),
    .bvalid  (s_bvalid),
    .bready  (s_bready),
    .araddr  (s_araddr),
    .arvalid (s_arvalid),
    .arready (s_arready),
    .rdata   (s_rdata),
    .rresp   (s_rresp),
    .rvalid  (s_rvalid),
    .rready  (s_rready),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .wr_strb (wr_strb),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_word (rd_word)
  );

  csr_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk        (clk),
    .srst_n     (srst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .wr_strb    (wr_strb),
    .cfg_word   (cfg_word),
    .trig_pulse (trig_pulse)
  );

  assign cap_en = rd_en && (rd_idx == IDX_W'(REG_CNTL));

  csr_status_snap #(
    .VST_W(VST_W), .FST_W(FST_W), .HI_W(HI_W), .SYNC_N(SYNC_N)
  ) u_snap (
    .clk       (clk),
    .srst_n    (srst_n),
    .pps_in    (pps_in),
    .vstat_in  (vstat_in),
    .vstat_vld (vstat_vld),
    .fstat_in  (fstat_in),
    .fstat_vld (fstat_vld),
    .cnt_hi_in (cur_count[CNT_W-1:DATA_W]),
    .cap_en    (cap_en),
    .pps_s     (pps_s),
    .vsnap_q   (vsnap_q),
    .fsnap_q   (fsnap_q),
    .cap_hi_q  (cap_hi_q)
  );

  // read word selection
  always_comb begin
    rd_word = '0;
    if (int'(rd_idx) < NUM_CFG) begin
      rd_word = cfg_word[rd_idx[3:0]];
    end else begin
      case (int'(rd_idx))
        REG_PPS:  rd_word = DATA_W'(pps_s);
        REG_VST:  rd_word = DATA_W'(vsnap_q);
        REG_FST:  rd_word = DATA_W'(fsnap_q);
        REG_CNTL: rd_word = cur_count[DATA_W-1:0];
        REG_CNTH: rd_word = DATA_W'(cap_hi_q);
        default:  rd_word = '0;
      endcase
    end
  end

  // field outputs
  assign go_write_pulse   = trig_pulse[0];
  assign gc_query_pulse   = trig_pulse[1];
  assign cfg_load_pulse   = trig_pulse[2];
  assign angle_save_pulse = trig_pulse[3];
  assign gc_out_pulse     = trig_pulse[4];

  assign cmd_code        = cfg_word[2][2:0];
  assign cmd_spare       = cfg_word[2][3];
  assign read_angle_mode = (cfg_word[2][2:0] == CMD_READ_ANGLE);
  assign angle_flush     = (cfg_word[2][2:0] == CMD_FLUSH);

  assign start_count = {cfg_word[5][HI_W-1:0], cfg_word[4]};
  assign pm_parity   = cfg_word[6][1];
  assign am_parity   = cfg_word[6][2];
  assign rd_pace     = cfg_word[8];
  assign spare_thr   = cfg_word[9];
  assign pm_delay    = cfg_word[10][DLY_W-1:0];
  assign am_delay    = cfg_word[10][2*DLY_W-1:DLY_W];
  assign out_delay   = cfg_word[11][DLY_W-1:0];
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
  parameter int VST_W = 9,
  parameter int FST_W = 3
) (
  input logic             clk,
  input logic             srst_n,
  input logic             s_awready,
  input logic             s_bvalid,
  input logic             s_bready,
  input logic             s_rvalid,
  input logic             s_rready,
  input logic [31:0]      s_rdata,
  input logic [4:0]       trig_v,
  input logic             vstat_vld,
  input logic [VST_W-1:0] vstat_in,
  input logic [VST_W-1:0] vsnap_q,
  input logic             fstat_vld,
  input logic [FST_W-1:0] fstat_in,
  input logic [FST_W-1:0] fsnap_q
);
  // R1
  bresp_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    s_bvalid && !s_bready |=> s_bvalid);

  // R1
  no_aw_while_b_chk: assert property (@(posedge clk) disable iff (!srst_n)
    s_bvalid |-> !s_awready);

  // R2
  rbeat_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

  // R4
  trig_single_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (trig_v != '0) |=> ((trig_v & $past(trig_v)) == '0));

  // R8
  vsnap_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    vstat_vld |=> vsnap_q == $past(vstat_in));

  // R8
  vsnap_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !vstat_vld |=> $stable(vsnap_q));

  // R9
  fsnap_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    fstat_vld |=> fsnap_q == $past(fstat_in));

  // R9
  fsnap_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !fstat_vld |=> $stable(fsnap_q));
endmodule

bind csr_bank csr_bank_chk #(.VST_W(VST_W), .FST_W(FST_W)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .s_awready (s_awready),
  .s_bvalid  (s_bvalid),
  .s_bready  (s_bready),
  .s_rvalid  (s_rvalid),
  .s_rready  (s_rready),
  .s_rdata   (s_rdata),
  .trig_v    (trig_pulse),
  .vstat_vld (vstat_vld),
  .vstat_in  (vstat_in),
  .vsnap_q   (vsnap_q),
  .fstat_vld (fstat_vld),
  .fstat_in  (fstat_in),
  .fsnap_q   (fsnap_q)
);

// File: tb/sim_csr_bank.sv
`timescale 1ns/1ps
module sim_csr_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  awaddr, araddr;
  logic        awvalid, wvalid, bready, arvalid, rready;
  logic [31:0] wdata;
  logic [3:0]  wstrb;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        pps_in;
  logic [8:0]  vstat_in;
  logic        vstat_vld;
  logic [2:0]  fstat_in;
  logic        fstat_vld;
  logic [47:0] cur_count;
  logic [4:0]  trig;
  logic [2:0]  cmd_code;
  logic        cmd_spare, read_angle_mode, angle_flush, pm_parity, am_parity;
  logic [47:0] start_count;
  logic [31:0] rd_pace, spare_thr;
  logic [15:0] pm_delay, am_delay, out_delay;

  int checks = 0;
  int errors = 0;
  int pcnt [5];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csr_bank u0 (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .pps_in(pps_in), .vstat_in(vstat_in), .vstat_vld(vstat_vld),
    .fstat_in(fstat_in), .fstat_vld(fstat_vld), .cur_count(cur_count),
    .go_write_pulse(trig[0]), .gc_query_pulse(trig[1]), .cfg_load_pulse(trig[2]),
    .angle_save_pulse(trig[3]), .gc_out_pulse(trig[4]),
    .cmd_code(cmd_code), .cmd_spare(cmd_spare),
    .read_angle_mode(read_angle_mode), .angle_flush(angle_flush),
    .start_count(start_count), .pm_parity(pm_parity), .am_parity(am_parity),
    .rd_pace(rd_pace), .spare_thr(spare_thr),
    .pm_delay(pm_delay), .am_delay(am_delay), .out_delay(out_delay)
  );

  always @(negedge clk) begin
    for (int i = 0; i < 5; i++) if (trig[i] === 1'b1) pcnt[i]++;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic axi_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0; bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
  endtask

  task automatic axi_rd(input logic [7:0] a, output logic [31:0] d, output logic [1:0] r);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    @(negedge clk);
    arvalid = 1'b0; d = rdata; r = rresp; rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic [1:0]  r;
    axi_rd(a, d, r);
    chk(tag, {30'd0, r, d}, {32'd0, exp});
  endtask

  task automatic t_reset;
    chk("R13 outputs after reset", {trig, cmd_code, read_angle_mode, angle_flush,
        pm_parity, am_parity, start_count}, 64'd0);
    for (int n = 0; n < 17; n++) rd_chk("R13 register after reset", 8'(4*n), 32'd0);
  endtask

  task automatic t_bus;
    // R1 response held while bready low, byte strobes merge
    axi_wr(8'h20, 32'hFFFF_FFFF, 4'hF);
    @(negedge clk);
    awaddr = 8'h20; wdata = 32'h0000_0000; wstrb = 4'b0010; awvalid = 1'b1; wvalid = 1'b1;
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 bvalid held without bready", {62'd0, bvalid, awready}, 64'd2);
    chk("R1 bresp OKAY", {62'd0, bresp}, 64'd0);
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
    chk("R1 bvalid cleared", {63'd0, bvalid}, 64'd0);
    rd_chk("R1 strobe merge", 8'h20, 32'hFFFF_00FF);
    chk("R7 rd_pace output", {32'd0, rd_pace}, 64'hFFFF_00FF);
    // R2 read beat held while rready low
    @(negedge clk);
    araddr = 8'h20; arvalid = 1'b1;
    @(negedge clk);
    arvalid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 rvalid and rdata held", {31'd0, rvalid, rdata}, {31'd0, 1'b1, 32'hFFFF_00FF});
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
    chk("R2 rvalid cleared", {63'd0, rvalid}, 64'd0);
  endtask

  task automatic t_reserved;
    axi_wr(8'h14, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R3 word 5 reserved bits", 8'h14, 32'h0000_FFFF);
    axi_wr(8'h08, 32'hFFFF_FFF8, 4'hF);
    rd_chk("R3 word 2 reserved bits", 8'h08, 32'h0000_0008);
    chk("R5 spare bit output", {60'd0, cmd_spare, cmd_code}, 64'h8);
    axi_wr(8'h18, 32'hFFFF_FFFE, 4'hF);
    rd_chk("R3 word 6 reserved bits", 8'h18, 32'h0000_0006);
    chk("R7 parity outputs", {62'd0, am_parity, pm_parity}, 64'h3);
    axi_wr(8'h18, 32'h0000_0004, 4'hF);
    chk("R7 parity second modulator only", {62'd0, am_parity, pm_parity}, 64'h2);
  endtask

  task automatic t_triggers;
    int regs [5] = '{0, 1, 3, 6, 7};
    for (int t = 0; t < 5; t++) begin
      int base [5];
      for (int i = 0; i < 5; i++) base[i] = pcnt[i];
      axi_wr(8'(4*regs[t]), 32'd0, 4'hF);
      axi_wr(8'(4*regs[t]), 32'd1, 4'hF);
      repeat (2) @(negedge clk);
      chk("R4 one pulse on 0-to-1", 64'(pcnt[t] - base[t]), 64'd1);
      axi_wr(8'(4*regs[t]), 32'd1, 4'hF);
      repeat (2) @(negedge clk);
      chk("R4 no pulse on 1-over-1", 64'(pcnt[t] - base[t]), 64'd1);
      axi_wr(8'(4*regs[t]), 32'd0, 4'hF);
      axi_wr(8'(4*regs[t]), 32'd1, 4'hF);
      repeat (2) @(negedge clk);
      chk("R4 re-armed pulse", 64'(pcnt[t] - base[t]), 64'd2);
      for (int i = 0; i < 5; i++)
        if (i != t) chk("R4 other triggers quiet", 64'(pcnt[i] - base[i]), 64'd0);
    end
  endtask

  task automatic t_command;
    axi_wr(8'h08, 32'd3, 4'hF);
    chk("R5 code 3 read-angle", {60'd0, cmd_code, read_angle_mode, angle_flush}, {60'd0, 3'd3, 2'b10});
    axi_wr(8'h08, 32'd4, 4'hF);
    chk("R5 code 4 flush", {60'd0, cmd_code, read_angle_mode, angle_flush}, {60'd0, 3'd4, 2'b01});
    axi_wr(8'h08, 32'd5, 4'hF);
    chk("R5 code 5 neither", {62'd0, read_angle_mode, angle_flush}, 64'd0);
  endtask

  task automatic t_config;
    axi_wr(8'h10, 32'h89AB_CDEF, 4'hF);
    axi_wr(8'h14, 32'h0000_4567, 4'hF);
    chk("R6 start count", {16'd0, start_count}, 64'h0000_4567_89AB_CDEF);
    axi_wr(8'h28, 32'h1234_0FA0, 4'hF);
    axi_wr(8'h2C, 32'h0000_07D0, 4'hF);
    axi_wr(8'h24, 32'h0BAD_F00D, 4'hF);
    chk("R7 delays", {16'd0, am_delay, pm_delay, out_delay}, 64'h0000_1234_0FA0_07D0);
    chk("R7 spare threshold", {32'd0, spare_thr}, 64'h0BAD_F00D);
  endtask

  task automatic t_status;
    vstat_in = 9'h1A5; fstat_in = 3'b101;
    repeat (2) @(negedge clk);
    rd_chk("R8 no load without strobe", 8'h34, 32'd0);
    rd_chk("R9 no load without strobe", 8'h38, 32'd0);
    @(negedge clk); vstat_vld = 1'b1;
    @(negedge clk); vstat_vld = 1'b0; vstat_in = 9'h042;
    rd_chk("R8 loaded on strobe", 8'h34, 32'h0000_01A5);
    @(negedge clk); fstat_vld = 1'b1;
    @(negedge clk); fstat_vld = 1'b0; fstat_in = 3'b010;
    rd_chk("R9 loaded on strobe", 8'h38, 32'h0000_0005);
    rd_chk("R8 held after strobe", 8'h34, 32'h0000_01A5);
  endtask

  task automatic t_pps;
    @(negedge clk); pps_in = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R10 PPS high", 8'h30, 32'd1);
    @(negedge clk); pps_in = 1'b0;
    repeat (3) @(negedge clk);
    rd_chk("R10 PPS low", 8'h30, 32'd0);
  endtask

  task automatic t_count;
    cur_count = 48'hABCD_1234_5678;
    rd_chk("R11 live low word", 8'h3C, 32'h1234_5678);
    cur_count = 48'h1111_2222_3333;
    rd_chk("R11 captured high half", 8'h40, 32'h0000_ABCD);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    logic [1:0]  r;
    axi_rd(8'h48, d, r);
    chk("R12 unmapped read zero OKAY", {30'd0, r, d}, 64'd0);
    axi_wr(8'h34, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R12 read-only write ignored", 8'h34, 32'h0000_01A5);
    axi_wr(8'h60, 32'hFFFF_FFFF, 4'hF);
    chk("R12 unmapped write no effect", {16'd0, start_count}, 64'h0000_4567_89AB_CDEF);
    rd_chk("R12 unmapped write pace unchanged", 8'h20, 32'hFFFF_00FF);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) pcnt[i] = 0;
    rst_n = 1'b0;
    awaddr = '0; araddr = '0; awvalid = 0; wvalid = 0; bready = 0; arvalid = 0; rready = 0;
    wdata = '0; wstrb = '0; pps_in = 0; vstat_in = '0; vstat_vld = 0;
    fstat_in = '0; fstat_vld = 0; cur_count = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_bus;
    t_reserved;
    t_triggers;
    t_command;
    t_config;
    t_status;
    t_pps;
    t_count;
    t_unmapped;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule